// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block keeps a small set of 64-bit list entries that describe virtual interrupts offered to one guest processor. A host agent fills or rewrites any entry through a write port and can read any entry back through a registered read port, for example to save and restore a guest context. The guest side has three operations. Acknowledge takes the most urgent eligible pending entry, returns its virtual ID and marks it active. End-of-interrupt (EOI) names a virtual ID and retires the matching active entry. A separate deactivate command finishes an entry when split EOI handling is selected.

Each entry can be tied to a physical interrupt. When such a linked entry is retired, the bank sends a one-cycle physical deactivation pulse that carries the entry's physical ID, so the host does not have to deactivate the physical source itself. A single running-priority register holds the priority of the interrupt being serviced. Only entries that are strictly more urgent than that value can be acknowledged.

Entry layout: bit 63 is the active flag and bit 62 is the pending flag (state 00 invalid, 01 pending, 10 active, 11 pending and active). Bit 61 is the physical-link flag. Bit 60 is the group bit, and only group 1 entries take part. Bits [55:48] hold the priority, where a lower value is more urgent. Bits [41:32] hold the physical ID and bits [31:0] the virtual ID.

Top module: `virq_list_bank`

## Requirements
- R1: After a synchronous reset every entry reads as zero (invalid), run_prio is 0xFF, and ack_valid and pdeact_valid are 0.
- R2: A host write with hwr_en loads hwr_data into entry hwr_idx at the clock edge. hrd_data is registered: after an edge it shows entry hrd_idx as it was before that edge.
- R3: One cycle after ack_req, ack_valid is 1 for exactly one cycle. The bank picks an eligible entry with the lowest priority value, and on a tie the lowest index wins. It then returns that entry's bits [31:0] on ack_id, sets the entry's state to active (bit 63 = 1, bit 62 = 0) and loads run_prio with the entry's priority.
- R4: An acknowledge that finds no eligible entry returns ack_id 1023 and changes neither the entries nor run_prio.
- R5: Acknowledging an entry in state pending+active (11) leaves it active only (10).
- R6: With split_mode = 0, EOI clears the active bit of the lowest-index active entry whose virtual ID equals eoi_id. Any EOI sets run_prio to 0xFF, unless an acknowledge in the same cycle loads a new priority.
- R7: When an EOI retires an entry with bit 61 = 1, whatever the value of split_mode, pdeact_valid is 1 for one cycle after the edge and pdeact_id equals the entry's bits [41:32].
- R8: With split_mode = 1, EOI on an entry with bit 61 = 0 only drops run_prio and the entry stays active. A dir_req then clears the active bit of the lowest-index active entry matching dir_id, and it pulses pdeact when that entry has bit 61 set and the same cycle's EOI did not already produce a pulse.
- R9: An entry is eligible only if it is pending, has group bit 60 = 1, and has a priority strictly below run_prio. Group 0 entries, and entries whose priority is equal to or above run_prio, are never acknowledged.
- R10: When ack_req and eoi_req arrive in the same cycle, both are judged on the state before the edge. The acknowledge uses the old run_prio. run_prio ends at the acknowledged priority if an entry was taken, and at 0xFF otherwise.
- R11: A host write to an entry overrides any guest update to that same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1 selects split priority-drop / deactivate handling |
| hwr_en | input | 1 | Host write strobe |
| hwr_idx | input | 2 | Entry index for the host write |
| hwr_data | input | 64 | Entry value to load |
| hrd_idx | input | 2 | Entry index for host readback |
| hrd_data | output | 64 | Registered readback of the selected entry |
| ack_req | input | 1 | Guest acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid, one cycle |
| ack_id | output | 32 | Acknowledged virtual ID or 1023 |
| eoi_req | input | 1 | Guest end-of-interrupt request |
| eoi_id | input | 32 | Virtual ID being ended |
| dir_req | input | 1 | Guest deactivate request |
| dir_id | input | 32 | Virtual ID being deactivated |
| run_prio | output | 8 | Running priority, 0xFF when idle |
| pdeact_valid | output | 1 | Physical deactivation pulse |
| pdeact_id | output | 10 | Physical ID to deactivate |

## Verification
Acknowledge and EOI can fall in the same cycle and compete for the running priority and, through a pending+active entry, for the same slot. The bench sets up directed cases for this. In one, an active entry is ended while a more urgent pending entry is taken in the same cycle. In the other, a less urgent pending entry has to be refused because the acknowledge still sees the old running priority. The random phase also raises ack_req and eoi_req together often. Each result is compared against a bench model that applies the same-cycle rules of R10 and R11 to the state before the edge.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int ENTRY_W   = 64;
  localparam int ACT_BIT   = 63;
  localparam int PEND_BIT  = 62;
  localparam int LINK_BIT  = 61;
  localparam int GRP_BIT   = 60;
  localparam int PRIO_LSB  = 48;
  localparam int PRIO_W    = 8;
  localparam int PID_LSB   = 32;
  localparam int PID_W     = 10;
  localparam int VID_W     = 32;
  localparam logic [VID_W-1:0]  SPURIOUS_ID = 32'd1023;
  localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;
  typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/virq_pick.sv
module virq_pick
  import virq_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_LR-1:0] pend,
  input  logic [NUM_LR-1:0] grp,
  input  logic [PRIO_W-1:0] prio [NUM_LR],
  input  logic [PRIO_W-1:0] run_prio,
  output logic              found,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [PRIO_W-1:0] sel_prio
);
  logic [NUM_LR-1:0] elig;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_elig
    assign elig[g] = pend[g] && grp[g] && (prio[g] < run_prio);
  end

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    found    = 1'b0;
    sel_idx  = '0;
    sel_prio = PRIO_IDLE;
    for (int i = 0; i < NUM_LR; i++) begin
      if (elig[i] && (!found || prio[i] < sel_prio)) begin
        found    = 1'b1;
        sel_idx  = IDX_W'(i);
        sel_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/virq_match.sv
module virq_match
  import virq_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_LR-1:0] act,
  input  logic [VID_W-1:0]  vid [NUM_LR],
  input  logic [VID_W-1:0]  want,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (!hit && act[i] && vid[i] == want) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/virq_list_bank.sv
module virq_list_bank
  import virq_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               split_mode,
  input  logic               hwr_en,
  input  logic [IDX_W-1:0]   hwr_idx,
  input  logic [ENTRY_W-1:0] hwr_data,
  input  logic [IDX_W-1:0]   hrd_idx,
  output logic [ENTRY_W-1:0] hrd_data,
  input  logic               ack_req,
  output logic               ack_valid,
  output logic [VID_W-1:0]   ack_id,
  input  logic               eoi_req,
  input  logic [VID_W-1:0]   eoi_id,
  input  logic               dir_req,
  input  logic [VID_W-1:0]   dir_id,
  output logic [PRIO_W-1:0]  run_prio,
  output logic               pdeact_valid,
  output logic [PID_W-1:0]   pdeact_id
);
  entry_t lr_q [NUM_LR];

  logic [NUM_LR-1:0] pend_v, act_v, grp_v;
  logic [PRIO_W-1:0] prio_a [NUM_LR];
  logic [VID_W-1:0]  vid_a  [NUM_LR];

  for (genvar g = 0; g < NUM_LR; g++) begin : g_fields
    assign pend_v[g] = lr_q[g][PEND_BIT];
    assign act_v[g]  = lr_q[g][ACT_BIT];
    assign grp_v[g]  = lr_q[g][GRP_BIT];
    assign prio_a[g] = lr_q[g][PRIO_LSB +: PRIO_W];
    assign vid_a[g]  = lr_q[g][VID_W-1:0];
  end

  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic [PRIO_W-1:0] pick_prio;

  virq_pick #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_pick (
    .pend(pend_v), .grp(grp_v), .prio(prio_a), .run_prio(run_prio),
    .found(pick_found), .sel_idx(pick_idx), .sel_prio(pick_prio)
  );

  logic             eoi_hit, dir_hit;
  logic [IDX_W-1:0] eoi_idx, dir_idx;

  virq_match #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_eoi_match (
    .act(act_v), .vid(vid_a), .want(eoi_id), .hit(eoi_hit), .hit_idx(eoi_idx)
  );

  virq_match #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_dir_match (
    .act(act_v), .vid(vid_a), .want(dir_id), .hit(dir_hit), .hit_idx(dir_idx)
  );

  logic ack_take, eoi_deact, dir_deact, eoi_pulse, dir_pulse;

  assign ack_take  = ack_req && pick_found;
  // linked entries always deactivate on EOI; others only outside split mode
  assign eoi_deact = eoi_req && eoi_hit && (!split_mode || lr_q[eoi_idx][LINK_BIT]);
  assign dir_deact = dir_req && dir_hit;
  assign eoi_pulse = eoi_deact && lr_q[eoi_idx][LINK_BIT];
  assign dir_pulse = dir_deact && lr_q[dir_idx][LINK_BIT];

  // entry storage: host write first, then acknowledge, then retire
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LR; i++) begin
      if (rst) begin
        lr_q[i] <= '0;
      end else if (hwr_en && hwr_idx == IDX_W'(i)) begin
        lr_q[i] <= hwr_data;
      end else if (ack_take && pick_idx == IDX_W'(i)) begin
        lr_q[i][PEND_BIT] <= 1'b0;
        lr_q[i][ACT_BIT]  <= 1'b1;
      end else if ((eoi_deact && eoi_idx == IDX_W'(i)) ||
                   (dir_deact && dir_idx == IDX_W'(i))) begin
        lr_q[i][ACT_BIT] <= 1'b0;
      end
    end
  end

  // running priority and registered guest-side results
  always_ff @(posedge clk) begin
    if (rst) begin
      run_prio     <= PRIO_IDLE;
      ack_valid    <= 1'b0;
      ack_id       <= '0;
      pdeact_valid <= 1'b0;
      pdeact_id    <= '0;
      hrd_data     <= '0;
    end else begin
      if (ack_take)     run_prio <= pick_prio;
      else if (eoi_req) run_prio <= PRIO_IDLE;
      ack_valid    <= ack_req;
      ack_id       <= ack_take ? vid_a[pick_idx] : SPURIOUS_ID;
      pdeact_valid <= eoi_pulse || dir_pulse;
      pdeact_id    <= eoi_pulse ? lr_q[eoi_idx][PID_LSB +: PID_W]
                                : lr_q[dir_idx][PID_LSB +: PID_W];
      hrd_data     <= lr_q[hrd_idx];
    end
  end

  // R3: a taken acknowledge loads the chosen priority
  a_r3_ack_loads_prio: assert property (@(posedge clk) disable iff (rst)
    ack_req && pick_found |=> run_prio == $past(pick_prio));

  // R4: nothing eligible gives the spurious ID
  a_r4_spurious: assert property (@(posedge clk) disable iff (rst)
    ack_req && !pick_found |=> ack_valid && ack_id == SPURIOUS_ID);

  // R9: the arbiter only offers pending group 1 entries above running priority
  a_r9_eligible: assert property (@(posedge clk) disable iff (rst)
    pick_found |-> lr_q[pick_idx][PEND_BIT] && lr_q[pick_idx][GRP_BIT] &&
                   (lr_q[pick_idx][PRIO_LSB +: PRIO_W] < run_prio));

  // R6: an EOI without a same-cycle acknowledge idles the running priority
  a_r6_eoi_drop: assert property (@(posedge clk) disable iff (rst)
    eoi_req && !ack_req |=> run_prio == PRIO_IDLE);

  // R7: a physical deactivation pulse only follows a guest retire command
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    pdeact_valid |-> $past(eoi_req || dir_req));
endmodule

// File: tb/virq_list_bank_bench.sv
`timescale 1ns/100ps
module virq_list_bank_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        split_mode, hwr_en, ack_req, eoi_req, dir_req;
  logic [1:0]  hwr_idx, hrd_idx;
  logic [63:0] hwr_data, hrd_data;
  logic [31:0] eoi_id, dir_id, ack_id;
  logic        ack_valid, pdeact_valid;
  logic [7:0]  run_prio;
  logic [9:0]  pdeact_id;

  always #2.5 clk = ~clk;

  virq_list_bank u_virq_list_bank (
    .clk(clk), .rst(rst), .split_mode(split_mode),
    .hwr_en(hwr_en), .hwr_idx(hwr_idx), .hwr_data(hwr_data),
    .hrd_idx(hrd_idx), .hrd_data(hrd_data),
    .ack_req(ack_req), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_req(eoi_req), .eoi_id(eoi_id), .dir_req(dir_req), .dir_id(dir_id),
    .run_prio(run_prio), .pdeact_valid(pdeact_valid), .pdeact_id(pdeact_id)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] mlr [4];
  logic [7:0]  mrpr;
  logic        exp_ack_v, exp_pd_v;
  logic [31:0] exp_ack_id;
  logic [9:0]  exp_pd_id;
  logic [63:0] exp_hrd;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [1:0] st, logic lnk, logic grp,
                                     logic [7:0] pr, logic [9:0] pid, logic [31:0] vid);
    logic [63:0] e;
    e = '0;
    e[63:62] = st; e[61] = lnk; e[60] = grp;
    e[55:48] = pr; e[41:32] = pid; e[31:0] = vid;
    return e;
  endfunction

  // bench model of the requirements, evaluated on the state before the edge
  task automatic model_step();
    logic found, eh, dh, edeact;
    logic [1:0] pidx, ei, di;
    logic [7:0] pp;
    found = 0; pidx = 0; pp = 8'hFF; eh = 0; dh = 0; ei = 0; di = 0;
    exp_hrd = mlr[hrd_idx];
    for (int i = 0; i < 4; i++) begin
      if (mlr[i][62] && mlr[i][60] && mlr[i][55:48] < mrpr &&
          (!found || mlr[i][55:48] < pp)) begin
        found = 1; pidx = 2'(i); pp = mlr[i][55:48];
      end
      if (!eh && eoi_req && mlr[i][63] && mlr[i][31:0] == eoi_id) begin eh = 1; ei = 2'(i); end
      if (!dh && dir_req && mlr[i][63] && mlr[i][31:0] == dir_id) begin dh = 1; di = 2'(i); end
    end
    edeact = eh && (!split_mode || mlr[ei][61]);
    exp_ack_v  = ack_req;
    exp_ack_id = (ack_req && found) ? mlr[pidx][31:0] : 32'd1023;
    exp_pd_v = 0; exp_pd_id = '0;
    if (edeact && mlr[ei][61]) begin exp_pd_v = 1; exp_pd_id = mlr[ei][41:32]; end
    else if (dh && mlr[di][61]) begin exp_pd_v = 1; exp_pd_id = mlr[di][41:32]; end
    if (ack_req && found) mrpr = pp;
    else if (eoi_req)     mrpr = 8'hFF;
    for (int i = 0; i < 4; i++) begin
      if (hwr_en && hwr_idx == 2'(i)) mlr[i] = hwr_data;
      else if (ack_req && found && pidx == 2'(i)) begin mlr[i][62] = 0; mlr[i][63] = 1; end
      else if ((edeact && ei == 2'(i)) || (dh && di == 2'(i))) mlr[i][63] = 0;
    end
  endtask

  task automatic idle_inputs();
    hwr_en = 0; ack_req = 0; eoi_req = 0; dir_req = 0;
  endtask

  // inputs are set at a falling edge; results are compared at the next one
  task automatic step(string tag);
    model_step();
    @(negedge clk);
    chk(tag, "ack_valid R3", 64'(ack_valid), 64'(exp_ack_v));
    if (exp_ack_v) chk(tag, "ack_id R3", 64'(ack_id), 64'(exp_ack_id));
    chk(tag, "pdeact_valid R7", 64'(pdeact_valid), 64'(exp_pd_v));
    if (exp_pd_v) chk(tag, "pdeact_id R7", 64'(pdeact_id), 64'(exp_pd_id));
    chk(tag, "run_prio R6", 64'(run_prio), 64'(mrpr));
    chk(tag, "hrd_data R2", hrd_data, exp_hrd);
    idle_inputs();
  endtask

  task automatic wr(logic [1:0] idx, logic [63:0] d, string tag);
    hwr_en = 1; hwr_idx = idx; hwr_data = d; step(tag);
  endtask

  task automatic ack(string tag);
    ack_req = 1; step(tag);
  endtask

  task automatic eoi(logic [31:0] id, string tag);
    eoi_req = 1; eoi_id = id; step(tag);
  endtask

  task automatic readback(logic [1:0] idx, logic [63:0] exp, string tag);
    hrd_idx = idx; step(tag);
    hrd_idx = idx; step(tag);
    chk(tag, "entry literal", hrd_data, exp);
  endtask

  function automatic logic [63:0] rand_entry();
    logic [7:0] pr;
    case ($urandom_range(0, 3))
      0: pr = 8'h00;
      1: pr = 8'h20;
      2: pr = 8'h40;
      default: pr = 8'($urandom);
    endcase
    return mk(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              $urandom_range(0, 7) != 0, pr, 10'($urandom), 32'($urandom_range(0, 7)));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1; split_mode = 0; hwr_idx = 0; hwr_data = '0; hrd_idx = 0;
    eoi_id = '0; dir_id = '0; idle_inputs();
    for (int i = 0; i < 4; i++) mlr[i] = '0;
    mrpr = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1", "run_prio", 64'(run_prio), 64'hFF);
    chk("R1", "ack_valid", 64'(ack_valid), 64'h0);
    chk("R1", "pdeact_valid", 64'(pdeact_valid), 64'h0);
    for (int i = 0; i < 4; i++) readback(2'(i), 64'h0, "R1");

    // R2 / R9: load entries, slot 3 is group 0 and most urgent
    wr(0, mk(2'b01, 0, 1, 8'h40, 10'h000, 32'd5), "R2");
    wr(1, mk(2'b01, 1, 1, 8'h20, 10'h1AB, 32'd6), "R2");
    wr(2, mk(2'b01, 0, 1, 8'h20, 10'h000, 32'd7), "R2");
    wr(3, mk(2'b01, 0, 0, 8'h00, 10'h000, 32'd8), "R2");
    readback(1, mk(2'b01, 1, 1, 8'h20, 10'h1AB, 32'd6), "R2");

    // R3: tie on 0x20 goes to slot 1, group 0 slot 3 skipped (R9)
    ack("R3");
    chk("R3", "ack_id literal", 64'(ack_id), 64'd6);
    // R9 / R4: slot 2 at 0x20 is not above running priority 0x20
    ack("R9");
    chk("R4", "spurious literal", 64'(ack_id), 64'd1023);
    // R7: EOI on linked entry pulses its physical ID
    eoi(32'd6, "R7");
    chk("R7", "pdeact_id literal", 64'(pdeact_id), 64'h1AB);
    readback(1, mk(2'b00, 1, 1, 8'h20, 10'h1AB, 32'd6), "R6");

    // R8: split mode keeps a non-linked entry active until dir_req
    ack("R3");
    chk("R3", "ack_id literal", 64'(ack_id), 64'd7);
    split_mode = 1;
    eoi(32'd7, "R8");
    chk("R8", "run_prio dropped", 64'(run_prio), 64'hFF);
    readback(2, mk(2'b10, 0, 1, 8'h20, 10'h000, 32'd7), "R8");
    dir_req = 1; dir_id = 32'd7; step("R8");
    readback(2, mk(2'b00, 0, 1, 8'h20, 10'h000, 32'd7), "R8");
    split_mode = 0;

    // R10: ack and EOI together, more urgent pending entry taken
    ack("R3");
    chk("R3", "ack_id literal", 64'(ack_id), 64'd5);
    wr(2, mk(2'b01, 0, 1, 8'h10, 10'h000, 32'd10), "R10");
    wr(1, mk(2'b01, 0, 1, 8'h60, 10'h000, 32'd9), "R10");
    ack_req = 1; eoi_req = 1; eoi_id = 32'd5; step("R10");
    chk("R10", "ack_id literal", 64'(ack_id), 64'd10);
    chk("R10", "run_prio literal", 64'(run_prio), 64'h10);
    // R10: ack sees old running priority 0x10, so 0x60 is refused
    ack_req = 1; eoi_req = 1; eoi_id = 32'd10; step("R10");
    chk("R10", "ack_id literal", 64'(ack_id), 64'd1023);
    chk("R10", "run_prio literal", 64'(run_prio), 64'hFF);

    // R5: pending+active entry becomes active only
    wr(0, mk(2'b11, 0, 1, 8'h30, 10'h000, 32'd12), "R5");
    ack("R5");
    chk("R5", "ack_id literal", 64'(ack_id), 64'd12);
    readback(0, mk(2'b10, 0, 1, 8'h30, 10'h000, 32'd12), "R5");

    // R11: host write wins over a same-cycle acknowledge of that slot
    eoi(32'd12, "R6");
    wr(3, mk(2'b01, 0, 1, 8'h05, 10'h000, 32'd20), "R11");
    ack_req = 1; hwr_en = 1; hwr_idx = 3;
    hwr_data = mk(2'b01, 0, 1, 8'h07, 10'h000, 32'd21); step("R11");
    chk("R11", "ack_id literal", 64'(ack_id), 64'd20);
    readback(3, mk(2'b01, 0, 1, 8'h07, 10'h000, 32'd21), "R11");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 49) == 0) split_mode = ~split_mode;
      ack_req = $urandom_range(0, 9) < 4;
      eoi_req = $urandom_range(0, 9) < 3;
      eoi_id  = 32'($urandom_range(0, 7));
      dir_req = $urandom_range(0, 19) < 3;
      dir_id  = 32'($urandom_range(0, 7));
      hwr_en  = $urandom_range(0, 9) < 2;
      hwr_idx = 2'($urandom);
      hwr_data = rand_entry();
      hrd_idx = 2'($urandom);
      step("R10");
    end
    finish_run();
  end
endmodule